// File: doc/BRIEF.md
# Four-Level DMA Request Priority Arbiter

This block decides which of four DMA request levels a shared transfer sequencer serves next. Each level raises its request line. While no transfer is running, the arbiter picks one eligible level, raises the matching one-hot grant line and presents the level number in binary to the sequencer. The grant stays fixed until the sequencer returns a one-cycle `xfer_done` pulse. Only after that pulse does the arbiter make its next decision.

A run-time mode input selects the priority scheme. In fixed mode, the lowest-numbered eligible level always wins. In rotating mode, the arbiter searches upward from a rotation pointer and wraps from level 3 to level 0. The level that was just served becomes the lowest priority, and the level above it becomes the highest. A per-level mask takes a level out of the contest without moving the rotation pointer. Any change of the mode input sends the pointer back to level 0.

The control is a two-state machine. `ST_IDLE` means no grant is held. It moves to `ST_BUSY` on the first clock edge that sees an eligible (requesting and unmasked) level, and otherwise stays in `ST_IDLE`. `ST_BUSY` means a grant is held. It returns to `ST_IDLE` on the edge that samples `xfer_done`, and otherwise stays in `ST_BUSY`.

Top module: `dma_level_arbiter`

## Requirements
- R1: While `gnt_valid` is 1, `gnt` has exactly one bit set, and that bit is bit `gnt_idx`. Level i is bit i of `req_lvl`, `mask_lvl` and `gnt`. While `gnt_valid` is 0, `gnt` is all zeros.
- R2: A grant is issued only from `ST_IDLE`. It appears on the clock edge after an eligible request is present, so registered outputs change one cycle after the request.
- R3: While a grant is held and `xfer_done` is low, `gnt`, `gnt_idx` and `gnt_valid` stay unchanged, whatever `req_lvl`, `mask_lvl` and `rot_mode` do.
- R4: On the edge that samples `xfer_done`=1 while a grant is held, the grant is removed. The earliest next grant comes on the following edge.
- R5: With `rot_mode`=0 (fixed), the lowest-numbered eligible level wins.
- R6: With `rot_mode`=1 (rotating), the winner is the first eligible level found by searching upward from the rotation pointer and wrapping after level 3. A grant to level w sets the pointer to w+1, and to 0 when w is 3.
- R7: A level whose `mask_lvl` bit is 1 is never granted. Masking does not move the rotation pointer.
- R8: Any change of `rot_mode` sets the rotation pointer to level 0.
- R9: When no level is both requesting and unmasked, no grant is issued and the rotation pointer keeps its value.
- R10: After reset, no grant is held, the state is `ST_IDLE`, the rotation pointer is 0, and the tracked mode is fixed.
- R11: `xfer_done` while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_lvl | input | 4 | Request lines, bit i = level i |
| mask_lvl | input | 4 | Mask bits, 1 removes that level from the contest |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| xfer_done | input | 1 | One-cycle pulse from the sequencer ending the granted transfer |
| gnt | output | 4 | One-hot grant/acknowledge, bit i = level i |
| gnt_idx | output | 2 | Binary number of the granted level |
| gnt_valid | output | 1 | 1 while a grant is held |

## Verification
The bench builds the arbiter with its default of four levels. This small size puts every pointer position within reach of a short directed run, including the wrap from level 3 back to level 0. Directed sequences walk the pointer through a full rotation. They then check the skip over idle levels, the masked level that leaves the pointer alone, and the two mode toggles that return it to level 0. With four levels, each expected winner can be worked out by hand from the requirements.

// File: rtl/dla_pkg.sv
package dla_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_t;
endpackage

// File: rtl/dla_rot_pick.sv
// Picks the first set bit of elig, scanning upward from base with wrap.
module dla_rot_pick #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [NUM_LVL-1:0] elig,
    input  logic [IDX_W-1:0]   base,
    output logic               hit,
    output logic [IDX_W-1:0]   win
);
    always_comb begin
        hit = 1'b0;
        win = '0;
        // scan from farthest offset down so the nearest hit is the final write
        for (int k = NUM_LVL - 1; k >= 0; k--) begin
            int pos;
            pos = int'(base) + k;
            if (pos >= NUM_LVL) pos = pos - NUM_LVL;
            if (elig[pos]) begin
                hit = 1'b1;
                win = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/dla_rot_ptr.sv
// Rotation pointer and mode tracking; provides the search base.
module dla_rot_ptr #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rot_mode,
    input  logic             fire,
    input  logic [IDX_W-1:0] win,
    output logic [IDX_W-1:0] base
);
    localparam logic [IDX_W-1:0] LAST_LVL = IDX_W'(NUM_LVL - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             mode_q;
    logic             mode_chg;
    logic [IDX_W-1:0] win_next;

    assign mode_chg = (rot_mode != mode_q);
    assign base     = (!rot_mode || mode_chg) ? '0 : ptr_q;
    assign win_next = (win == LAST_LVL) ? '0 : win + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= rot_mode;
            if (fire && rot_mode) begin
                ptr_q <= win_next;
            end else if (mode_chg) begin
                ptr_q <= '0;
            end
        end
    end
endmodule

// File: rtl/dma_level_arbiter.sv
module dma_level_arbiter
    import dla_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_lvl,
    input  logic [NUM_LVL-1:0] mask_lvl,
    input  logic               rot_mode,
    input  logic               xfer_done,
    output logic [NUM_LVL-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               gnt_valid
);
    arb_state_t       state_q, state_d;
    logic [NUM_LVL-1:0] elig;
    logic             hit;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] base;
    logic             fire;

    assign elig = req_lvl & ~mask_lvl;
    assign fire = (state_q == ST_IDLE) && hit;

    dla_rot_pick #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_pick (
        .elig (elig),
        .base (base),
        .hit  (hit),
        .win  (win)
    );

    dla_rot_ptr #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rot_mode (rot_mode),
        .fire     (fire),
        .win      (win),
        .base     (base)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)       state_d = ST_BUSY;
            ST_BUSY: if (xfer_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt       <= '0;
            gnt_idx   <= '0;
            gnt_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (hit) begin
                    gnt       <= NUM_LVL'(1) << win;
                    gnt_idx   <= win;
                    gnt_valid <= 1'b1;
                end
                ST_BUSY: if (xfer_done) begin
                    gnt       <= '0;
                    gnt_valid <= 1'b0;
                end
                default: begin
                    gnt       <= '0;
                    gnt_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dla_checker.sv
module dla_checker #(
    parameter int NUM_LVL = 4,
    parameter int IDX_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_LVL-1:0] req_lvl,
    input logic [NUM_LVL-1:0] mask_lvl,
    input logic               rot_mode,
    input logic               xfer_done,
    input logic [NUM_LVL-1:0] gnt,
    input logic [IDX_W-1:0]   gnt_idx,
    input logic               gnt_valid
);
    localparam logic [NUM_LVL-1:0] ONE = NUM_LVL'(1);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1 && gnt[gnt_idx])); // R1
    AST_NO_GNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt == '0)); // R1
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt) && $stable(gnt_idx))); // R3
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && xfer_done) |=> !gnt_valid); // R4
    AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> (($past(req_lvl) & ~$past(mask_lvl) & gnt) != '0)); // R7
    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && ((req_lvl & ~mask_lvl) == '0)) |=> !gnt_valid); // R9
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_valid) && !$past(rot_mode)) |->
            (($past(req_lvl) & ~$past(mask_lvl) & (gnt - ONE)) == '0)); // R5
    AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && xfer_done && ((req_lvl & ~mask_lvl) == '0)) |=> !gnt_valid); // R11
endmodule

bind dma_level_arbiter dla_checker #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_dma_level_arbiter.sv
module tb_dma_level_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_lvl = '0;
    logic [3:0] mask_lvl = '0;
    logic       rot_mode = 1'b0;
    logic       xfer_done = 1'b0;
    logic [3:0] gnt;
    logic [1:0] gnt_idx;
    logic       gnt_valid;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    dma_level_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_lvl(req_lvl), .mask_lvl(mask_lvl),
        .rot_mode(rot_mode), .xfer_done(xfer_done),
        .gnt(gnt), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_none(string tag);
        chk({tag, " gnt"}, {4'h0, gnt}, 8'h00);
        chk({tag, " valid"}, {7'h0, gnt_valid}, 8'h00);
    endtask

    task automatic expect_lvl(string tag, int lvl);
        chk({tag, " gnt"}, {4'h0, gnt}, 8'(1 << lvl));
        chk({tag, " idx"}, {6'h0, gnt_idx}, 8'(lvl));
        chk({tag, " valid"}, {7'h0, gnt_valid}, 8'h01);
    endtask

    // ends the running transfer; grant must be gone after the done edge
    task automatic finish_xfer(string tag);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        expect_none({tag, " R4 release"});
    endtask

    task automatic t_reset();
        expect_none("R10 reset");
        chk("R10 reset idx", {6'h0, gnt_idx}, 8'h00);
    endtask

    task automatic t_fixed();
        req_lvl = 4'b1111; tick(); expect_lvl("R5 fixed all", 0);
        finish_xfer("R5");
        tick(); expect_lvl("R5 fixed repeat", 0);
        req_lvl = 4'b1100;
        finish_xfer("R5");
        tick(); expect_lvl("R5 fixed 1100", 2);
        req_lvl = 4'b0000;
        finish_xfer("R5");
    endtask

    task automatic t_rotate_cycle();
        rot_mode = 1'b1; tick();
        req_lvl = 4'b1111;
        for (int i = 0; i < 5; i++) begin
            tick(); expect_lvl("R6 rotate", i % 4);
            if (i == 4) req_lvl = 4'b0000;
            finish_xfer("R6");
        end
        // pointer now at 1
    endtask

    task automatic t_rotate_skip();
        req_lvl = 4'b1001;
        tick(); expect_lvl("R6 skip wrap", 3);
        finish_xfer("R6");
        tick(); expect_lvl("R6 after wrap", 0);
        req_lvl = 4'b0000;
        finish_xfer("R6");
        // pointer at 1
    endtask

    task automatic t_mask();
        mask_lvl = 4'b0010; req_lvl = 4'b1111;
        tick(); expect_lvl("R7 masked skip", 2);
        mask_lvl = 4'b0000;
        finish_xfer("R7");
        tick(); expect_lvl("R7 pointer after mask", 3);
        req_lvl = 4'b0000;
        finish_xfer("R7");
        // pointer at 0
        mask_lvl = 4'b1111; req_lvl = 4'b1111;
        for (int i = 0; i < 3; i++) begin
            tick(); expect_none("R9 all masked");
        end
        mask_lvl = 4'b0000;
        tick(); expect_lvl("R9 pointer kept", 0);
        req_lvl = 4'b0000;
        finish_xfer("R9");
        for (int i = 0; i < 3; i++) begin
            tick(); expect_none("R9 no request");
        end
        req_lvl = 4'b1111;
        tick(); expect_lvl("R9 pointer kept idle", 1);
        req_lvl = 4'b0000;
        finish_xfer("R9");
        // pointer at 2
    endtask

    task automatic t_hold();
        req_lvl = 4'b0001;
        tick(); expect_lvl("R2 grant after request", 0);
        req_lvl = 4'b1111; mask_lvl = 4'b0001;
        for (int i = 0; i < 3; i++) begin
            tick(); expect_lvl("R3 hold", 0);
        end
        mask_lvl = 4'b0000;
        finish_xfer("R4");
        tick(); expect_lvl("R4 regrant next edge", 1);
        req_lvl = 4'b0000;
        finish_xfer("R4");
        // pointer at 2
    endtask

    task automatic t_mode_switch();
        rot_mode = 1'b0; tick();
        rot_mode = 1'b1; tick();
        req_lvl = 4'b1111;
        tick(); expect_lvl("R8 pointer reset", 0);
        req_lvl = 4'b0000;
        finish_xfer("R8");
        rot_mode = 1'b0; tick();
        req_lvl = 4'b1110;
        tick(); expect_lvl("R5 fixed after rotate", 1);
        finish_xfer("R5");
        tick(); expect_lvl("R5 fixed again", 1);
        req_lvl = 4'b0000;
        finish_xfer("R5");
    endtask

    task automatic t_idle_done();
        xfer_done = 1'b1; tick();
        xfer_done = 1'b0; expect_none("R11 idle done");
        tick(); expect_none("R11 idle done later");
        req_lvl = 4'b0100;
        tick(); expect_lvl("R11 normal after idle done", 2);
        req_lvl = 4'b0000;
        finish_xfer("R11");
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_rotate_cycle();
        t_rotate_skip();
        t_mask();
        t_hold();
        t_mode_switch();
        t_idle_done();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end
endmodule